// File: doc/BRIEF.md
# Flash Write Request Chunk Splitter

This block turns one linear write request, given as a global byte offset and a byte length, into a series of sub-requests for the flash program engines. The global offset is split into a chip index (upper bits) and an in-chip offset (lower bits). An in-chip offset that does not sit on a bus-word boundary first produces a short single-word sub-request that covers the gap up to the next boundary. After that, the block cuts the rest into buffered-program chunks. No chunk ever crosses a write-buffer boundary. When a chunk ends exactly at the end of a chip, the cursor moves to offset zero of the next chip.

The block issues one sub-request at a time on a valid/ready channel. While `sub_valid` is high and `sub_ready` is low, the sub-request stays frozen: all of its fields hold their values until the engine takes it. After the engine accepts it, the block waits for a single-cycle `done_valid` pulse. The pulse's `done_err` bit either aborts the request or lets the splitter continue. Requests are taken on `req_valid`/`req_ready`, and `req_ready` is high only while the block is idle. A finished request gives a one-cycle `fin_valid` pulse with `fin_err`. `bytes_done` holds the running count of bytes that the engines reported as written.

Top module: `flash_write_splitter`

## Requirements
- R1: A sub-request's `sub_chip` equals the request offset shifted right by `CHIP_SHIFT`, and its `sub_offset` is the low `CHIP_SHIFT` bits, until a chip advance happens.
- R2: When the in-chip offset is not a multiple of the bus width (2^`BUS_LOG2` bytes), the sub-request has `sub_single`=1. Its size is the bus width minus (offset mod bus width), capped at the remaining length.
- R3: Otherwise `sub_single`=0, and the size is the buffer size minus (offset mod buffer size), capped at the remaining length. The buffer size is 2^(`INTERLEAVE_LOG2`+`BUF_EXP`) bytes. Every size is non-zero.
- R4: When a completed sub-request brings the in-chip offset to the chip size, the next sub-request has chip index +1 and offset 0.
- R5: When that advance would go past chip `NUM_CHIPS`-1, the request finishes with `fin_err`=0 and issues nothing more.
- R6: A zero-length request gives `fin_valid` one cycle after acceptance, with `fin_err`=0, `bytes_done`=0 and no sub-request.
- R7: A `done_err`=1 pulse ends the request. `fin_valid` follows with `fin_err`=1, and no further sub-request is issued.
- R8: `bytes_done` clears when a request is accepted and grows by the sub-request size after each error-free completion. A failed sub-request adds nothing.
- R9: At most one sub-request is outstanding. `sub_valid` stays low from acceptance until `done_valid`. Under back-pressure the offered sub-request stays valid with unchanged fields.
- R10: After reset, `req_ready`=1, `sub_valid`=0, `fin_valid`=0 and `bytes_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Splitter idle, request taken |
| req_offset | input | ADDR_W | Global byte offset of the request |
| req_len | input | LEN_W | Request length in bytes |
| sub_valid | output | 1 | Sub-request offered |
| sub_ready | input | 1 | Engine takes the sub-request |
| sub_single | output | 1 | 1: single-word path, 0: buffered program |
| sub_chip | output | ADDR_W-CHIP_SHIFT | Target chip index |
| sub_offset | output | CHIP_SHIFT | Byte offset within the chip |
| sub_size | output | INTERLEAVE_LOG2+BUF_EXP+1 | Sub-request size in bytes |
| done_valid | input | 1 | Engine completion pulse |
| done_err | input | 1 | Completion carries an error |
| fin_valid | output | 1 | Request finished (one cycle) |
| fin_err | output | 1 | Request ended on an engine error |
| bytes_done | output | LEN_W | Bytes confirmed written so far |

## Verification
Requests are tried in several shapes, and each shape separates a different part of the chunking rule:
- An aligned request inside one buffer checks the plain capping rule.
- Aligned requests over several buffers, and one starting mid-buffer, check the boundary remainder against the cap.
- Unaligned starts, including one whose head is capped by the length, exercise the single-word path.
- Offsets just below a chip end check the advance.
- The same pattern on the last chip checks the early finish.
- Zero length is tried on its own.

Error pulses on the first and on a later sub-request show that the abort stops issue and freezes the byte count. A varying stall on `sub_ready` checks that the offered fields hold.

// File: rtl/flash_split_pkg.sv
package flash_split_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } split_state_e;

endpackage

// File: rtl/flash_chunk_calc.sv
module flash_chunk_calc #(
  parameter int CHIP_SHIFT = 16,
  parameter int LEN_W      = 20,
  parameter int BUS_LOG2   = 2,
  parameter int BUF_LOG2   = 5,
  parameter int SIZE_W     = BUF_LOG2 + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  offered,
  input  logic [CHIP_SHIFT-1:0] in_ofs,
  input  logic [LEN_W-1:0]      rem,
  output logic                  single,
  output logic [SIZE_W-1:0]     size
);

  localparam int BUS_BYTES = 1 << BUS_LOG2;
  localparam int BUF_BYTES = 1 << BUF_LOG2;

  logic [SIZE_W-1:0] head_gap;
  logic [SIZE_W-1:0] buf_gap;
  logic [SIZE_W-1:0] span;

  generate
    if (BUS_LOG2 == 0) begin : g_byte_bus
      assign single   = 1'b0;
      assign head_gap = '0;
    end else begin : g_wide_bus
      assign single   = |in_ofs[BUS_LOG2-1:0];
      assign head_gap = SIZE_W'(BUS_BYTES) - SIZE_W'(in_ofs[BUS_LOG2-1:0]);
    end
  endgenerate

  assign buf_gap = SIZE_W'(BUF_BYTES) - SIZE_W'(in_ofs[BUF_LOG2-1:0]);
  assign span    = single ? head_gap : buf_gap;

  always_comb begin
    if (rem < LEN_W'(span)) size = rem[SIZE_W-1:0];
    else                    size = span;
  end

  AST_NO_BUF_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    offered && !single |-> ((SIZE_W+1)'(in_ofs[BUF_LOG2-1:0]) + (SIZE_W+1)'(size)) <= (SIZE_W+1)'(BUF_BYTES)); // R3

  AST_HEAD_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    offered && single |-> (size != '0) && (size <= SIZE_W'(BUS_BYTES))); // R2

  AST_SIZE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    offered |-> (size != '0) && (LEN_W'(size) <= rem)); // R3

endmodule

// File: rtl/flash_split_cursor.sv
module flash_split_cursor #(
  parameter int ADDR_W     = 18,
  parameter int CHIP_SHIFT = 16,
  parameter int NUM_CHIPS  = 4,
  parameter int LEN_W      = 20,
  parameter int SIZE_W     = 6,
  parameter int CHIP_W     = ADDR_W - CHIP_SHIFT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [ADDR_W-1:0]     load_ofs,
  input  logic [LEN_W-1:0]      load_len,
  input  logic                  advance,
  input  logic [SIZE_W-1:0]     step,
  output logic [CHIP_W-1:0]     chip,
  output logic [CHIP_SHIFT-1:0] in_ofs,
  output logic [LEN_W-1:0]      rem,
  output logic [LEN_W-1:0]      bytes_done,
  output logic                  ends_after
);

  logic [CHIP_SHIFT:0] next_ofs;
  logic                wrap;
  logic [LEN_W-1:0]    rem_next;
  logic                on_last_chip;

  assign next_ofs     = {1'b0, in_ofs} + (CHIP_SHIFT+1)'(step);
  assign wrap         = next_ofs[CHIP_SHIFT];
  assign rem_next     = rem - LEN_W'(step);
  assign on_last_chip = (chip == CHIP_W'(NUM_CHIPS - 1));
  assign ends_after   = (rem_next == '0) || (wrap && on_last_chip);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chip       <= '0;
      in_ofs     <= '0;
      rem        <= '0;
      bytes_done <= '0;
    end else if (load) begin
      chip       <= load_ofs[ADDR_W-1:CHIP_SHIFT];
      in_ofs     <= load_ofs[CHIP_SHIFT-1:0];
      rem        <= load_len;
      bytes_done <= '0;
    end else if (advance) begin
      rem        <= rem_next;
      bytes_done <= bytes_done + LEN_W'(step);
      if (wrap) begin
        chip   <= chip + CHIP_W'(1);
        in_ofs <= '0;
      end else begin
        in_ofs <= next_ofs[CHIP_SHIFT-1:0];
      end
    end
  end

  AST_BYTES_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> (rem + bytes_done) == ($past(rem) + $past(bytes_done))); // R8

  AST_CHIP_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) && (chip != $past(chip)) |-> (chip == $past(chip) + CHIP_W'(1)) && (in_ofs == '0)); // R4

endmodule

// File: rtl/flash_split_ctrl.sv
module flash_split_ctrl
  import flash_split_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_len_zero,
  input  logic sub_ready,
  input  logic done_valid,
  input  logic done_err,
  input  logic ends_after,
  output logic req_ready,
  output logic sub_valid,
  output logic load,
  output logic advance,
  output logic fin_valid,
  output logic fin_err
);

  split_state_e state, state_nx;
  logic         err_q;

  always_comb begin
    state_nx  = state;
    req_ready = 1'b0;
    sub_valid = 1'b0;
    load      = 1'b0;
    advance   = 1'b0;
    fin_valid = 1'b0;
    fin_err   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          load     = 1'b1;
          state_nx = req_len_zero ? ST_FIN : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        sub_valid = 1'b1;
        if (sub_ready) state_nx = ST_WAIT;
      end
      ST_WAIT: begin
        if (done_valid) begin
          if (done_err) begin
            state_nx = ST_FIN;
          end else begin
            advance  = 1'b1;
            state_nx = ends_after ? ST_FIN : ST_ISSUE;
          end
        end
      end
      ST_FIN: begin
        fin_valid = 1'b1;
        fin_err   = err_q;
        state_nx  = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (load) err_q <= 1'b0;
      else if (state == ST_WAIT && done_valid && done_err) err_q <= 1'b1;
    end
  end

  AST_ZERO_LEN_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_len_zero |=> fin_valid && !fin_err); // R6

  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) && done_valid && done_err |=> fin_valid && fin_err && !sub_valid); // R7

  AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid |=> !fin_valid && req_ready); // R5

endmodule

// File: rtl/flash_write_splitter.sv
module flash_write_splitter #(
  parameter int ADDR_W          = 18,
  parameter int CHIP_SHIFT      = 16,
  parameter int NUM_CHIPS       = 4,
  parameter int LEN_W           = 20,
  parameter int BUS_LOG2        = 2,
  parameter int INTERLEAVE_LOG2 = 0,
  parameter int BUF_EXP         = 5,
  localparam int CHIP_W         = ADDR_W - CHIP_SHIFT,
  localparam int BUF_LOG2       = INTERLEAVE_LOG2 + BUF_EXP,
  localparam int SIZE_W         = BUF_LOG2 + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_offset,
  input  logic [LEN_W-1:0]      req_len,
  output logic                  sub_valid,
  input  logic                  sub_ready,
  output logic                  sub_single,
  output logic [CHIP_W-1:0]     sub_chip,
  output logic [CHIP_SHIFT-1:0] sub_offset,
  output logic [SIZE_W-1:0]     sub_size,
  input  logic                  done_valid,
  input  logic                  done_err,
  output logic                  fin_valid,
  output logic                  fin_err,
  output logic [LEN_W-1:0]      bytes_done
);

  logic             load;
  logic             advance;
  logic             ends_after;
  logic [LEN_W-1:0] rem;

  flash_split_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_len_zero (req_len == '0),
    .sub_ready    (sub_ready),
    .done_valid   (done_valid),
    .done_err     (done_err),
    .ends_after   (ends_after),
    .req_ready    (req_ready),
    .sub_valid    (sub_valid),
    .load         (load),
    .advance      (advance),
    .fin_valid    (fin_valid),
    .fin_err      (fin_err)
  );

  flash_split_cursor #(
    .ADDR_W     (ADDR_W),
    .CHIP_SHIFT (CHIP_SHIFT),
    .NUM_CHIPS  (NUM_CHIPS),
    .LEN_W      (LEN_W),
    .SIZE_W     (SIZE_W),
    .CHIP_W     (CHIP_W)
  ) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_ofs   (req_offset),
    .load_len   (req_len),
    .advance    (advance),
    .step       (sub_size),
    .chip       (sub_chip),
    .in_ofs     (sub_offset),
    .rem        (rem),
    .bytes_done (bytes_done),
    .ends_after (ends_after)
  );

  flash_chunk_calc #(
    .CHIP_SHIFT (CHIP_SHIFT),
    .LEN_W      (LEN_W),
    .BUS_LOG2   (BUS_LOG2),
    .BUF_LOG2   (BUF_LOG2),
    .SIZE_W     (SIZE_W)
  ) u_calc (
    .clk     (clk),
    .rst_n   (rst_n),
    .offered (sub_valid),
    .in_ofs  (sub_offset),
    .rem     (rem),
    .single  (sub_single),
    .size    (sub_size)
  );

  AST_SUB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && !sub_ready |=> sub_valid && $stable(sub_chip) && $stable(sub_offset)
                               && $stable(sub_size) && $stable(sub_single)); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_ready |=> !sub_valid); // R9

endmodule

// File: tb/flash_write_splitter_tb.sv
module flash_write_splitter_tb;

  localparam int ADDR_W = 18;
  localparam int CSH    = 16;
  localparam int NCHIP  = 4;
  localparam int LEN_W  = 20;
  localparam int BUSB   = 4;
  localparam int BUFB   = 32;

  typedef struct packed {
    int chip;
    int ofs;
    int size;
    bit single;
  } sub_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_offset = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic sub_valid;
  logic sub_ready = 1'b0;
  logic sub_single;
  logic [1:0] sub_chip;
  logic [15:0] sub_offset;
  logic [5:0] sub_size;
  logic done_valid = 1'b0;
  logic done_err = 1'b0;
  logic fin_valid;
  logic fin_err;
  logic [LEN_W-1:0] bytes_done;

  int tests = 0;
  int fails = 0;
  sub_t expq[$];
  int err_at = -1;
  int sub_idx = 0;
  int running = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_write_splitter u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_len(req_len),
    .sub_valid(sub_valid), .sub_ready(sub_ready),
    .sub_single(sub_single), .sub_chip(sub_chip),
    .sub_offset(sub_offset), .sub_size(sub_size),
    .done_valid(done_valid), .done_err(done_err),
    .fin_valid(fin_valid), .fin_err(fin_err),
    .bytes_done(bytes_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Engine model: monitor, scoreboard compare, back-pressure and completion.
  initial begin
    forever begin
      @(negedge clk);
      if (sub_valid) begin
        sub_t got;
        sub_t exp;
        int stall;
        bit is_err;
        got.chip = int'(sub_chip); got.ofs = int'(sub_offset);
        got.size = int'(sub_size); got.single = sub_single;
        stall = (sub_idx % 3 == 1) ? 3 : 0;
        for (int k = 0; k < stall; k++) begin
          @(negedge clk);
          check(sub_valid && int'(sub_offset) == got.ofs && int'(sub_size) == got.size
                && int'(sub_chip) == got.chip && sub_single == got.single,
                "R9", "held under stall", int'(sub_size), got.size);
        end
        sub_ready = 1'b1;
        if (expq.size() == 0) begin
          check(1'b0, "R9", "unexpected sub-request", got.ofs, -1);
          exp = got;
        end else begin
          exp = expq.pop_front();
        end
        check(got.chip == exp.chip, "R1/R4", "sub_chip", got.chip, exp.chip);
        check(got.ofs == exp.ofs, "R1/R4", "sub_offset", got.ofs, exp.ofs);
        check(got.single == exp.single, "R2", "sub_single", int'(got.single), int'(exp.single));
        check(got.size == exp.size, "R3", "sub_size", got.size, exp.size);
        @(negedge clk);
        sub_ready = 1'b0;
        for (int k = 0; k < 2; k++) begin
          check(!sub_valid, "R9", "no second outstanding", int'(sub_valid), 0);
          @(negedge clk);
        end
        is_err = (sub_idx == err_at);
        done_valid = 1'b1;
        done_err = is_err;
        @(negedge clk);
        done_valid = 1'b0;
        done_err = 1'b0;
        if (!is_err) running += got.size;
        check(int'(bytes_done) == running, "R8", "bytes_done after completion",
              int'(bytes_done), running);
        sub_idx++;
      end
    end
  end

  task automatic run_req(input int off, input int len, input int err_idx, input string tag);
    int chip, io, r, idx, total;
    bit eerr;
    sub_t s;
    chip = off >> CSH; io = off & ((1 << CSH) - 1); r = len; idx = 0; total = 0; eerr = 0;
    while (r > 0) begin
      if ((io % BUSB) != 0) begin s.single = 1; s.size = BUSB - (io % BUSB); end
      else begin s.single = 0; s.size = BUFB - (io % BUFB); end
      if (s.size > r) s.size = r;
      s.chip = chip; s.ofs = io;
      expq.push_back(s);
      if (idx == err_idx) begin eerr = 1; break; end
      total += s.size; r -= s.size; io += s.size;
      if (io == (1 << CSH)) begin
        chip++; io = 0;
        if (chip == NCHIP) break;
      end
      idx++;
    end
    err_at = err_idx; sub_idx = 0; running = 0;
    @(negedge clk);
    req_valid = 1'b1; req_offset = ADDR_W'(off); req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    while (!fin_valid) @(negedge clk);
    check(fin_err == eerr, (eerr ? "R7" : "R5"), {tag, " fin_err"}, int'(fin_err), int'(eerr));
    check(int'(bytes_done) == total, "R8", {tag, " final bytes_done"}, int'(bytes_done), total);
    check(expq.size() == 0, (eerr ? "R7" : "R5"), {tag, " subs left"}, expq.size(), 0);
    expq.delete();
    @(negedge clk);
    check(req_ready && !sub_valid, "R9", {tag, " idle after finish"}, int'(req_ready), 1);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "req_ready after reset", int'(req_ready), 1);
    check(!sub_valid && !fin_valid, "R10", "outputs idle", int'(sub_valid), 0);
    check(bytes_done == '0, "R10", "bytes_done after reset", int'(bytes_done), 0);

    run_req(32'h00100, 20, -1, "R3 aligned single chunk");
    run_req(32'h00040, 100, -1, "R3 multi buffer");
    run_req(32'h0001C, 10, -1, "R3 mid buffer");
    run_req(32'h00103, 50, -1, "R2 unaligned head");
    run_req(32'h00201, 2, -1, "R2 capped head");
    run_req(32'h0FFF0, 40, -1, "R4 chip cross");
    run_req(32'h1FFFE, 6, -1, "R4 head at chip end");
    run_req(32'h3FFE2, 100, -1, "R5 last chip end");
    run_req(32'h00500, 0, -1, "R6 zero length");
    run_req(32'h00040, 100, 1, "R7 error second");
    run_req(32'h00103, 50, 0, "R7 error first");
    run_req(32'h10020, 64, -1, "R1 chip one aligned");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule